// File: doc/BRIEF.md
# DMA Address Remapping Unit

This block sits between DMA-capable devices and the memory system and turns each device bus address into a physical address. It looks the address up in a flat table of 32-bit entries kept in system memory. Each table entry maps one 4 KB page. The most recent mappings are kept in a small, fully associative translation cache. When the cache misses, the block reads one table word through a simple memory read port. Addresses in a fixed high window skip the table altogether.

Software programs the unit through four word registers: control, table base, table size and status. The control register holds the enable bit and two maintenance requests, flush-everything and drop-one-page. Each request clears itself once the cache has acted on it. Changing the base or the size does not touch the cache, so software follows such a change with a flush. A request that falls outside the table, or that hits an entry marked not valid, gets a fault response and sets a sticky status bit.

Top module: `dma_remap`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and mem_req are 0, and the control register (address 0) and the status register (address 3) read as zero.
- R2: A request with bit 39 set bypasses the table, whatever the enable bit holds. The block returns the address minus 0x80_0000_0000 with no fault, makes no memory read, and responds one cycle after acceptance.
- R3: While the enable bit (control bit 31) is 0, a request below the window comes back unchanged, with no fault and no memory read, one cycle after acceptance.
- R4: On a cache miss with translation enabled, the block makes exactly one memory read at base*4096 + page*4, where page = address bits [31:12] and base is register 1. The response comes one cycle after mem_rvalid. It carries (entry bits [23:0] << 12) | address bits [11:0], where entry bit 31 is the valid flag.
- R5: A second request to a cached page makes no memory read, responds one cycle after acceptance, and returns the same translation.
- R6: A request faults when any of address bits [38:32] is set, or when page+1 >= size*1024, with size taken from register 2 bits [9:0]. This keeps the last table slot unusable. Such a request makes no memory read and returns rsp_fault=1 with address 0. Every fault sets status bit 0, which stays set until software writes 1 to it.
- R7: A fetched entry with bit 31 clear gives a fault response and is not cached, so a repeated request reads memory again.
- R8: Writing control bit 30 empties the whole cache. The bit reads 1 in the cycle after the write and 0 from the following cycle on.
- R9: Writing control bit 29 together with a page number in bits [19:0] drops only that page from the cache. Other cached pages still hit. Bit 29 clears after one cycle.
- R10: A flush that arrives while a table read is outstanding still lets that request complete with the fetched translation, but the entry is not cached.
- R11: Writing a new table base leaves cached translations in use until a flush. After the flush, the next miss reads from the new base.
- R12: The cache holds 8 entries replaced in round-robin order. After 9 distinct pages miss in turn, the first page is evicted and the second page still hits.
- R13: req_ready is 0 while a maintenance request is pending and while a table read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Register write address (0 ctrl, 1 base, 2 size, 3 status) |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 2 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translation request accepted when high with req_valid |
| req_addr | input | 40 | Device bus address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_paddr | output | 40 | Translated physical address |
| mem_req | output | 1 | One-cycle table read request |
| mem_addr | output | 40 | Byte address of the table word |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | 32 | Table word |

## Verification
The bench goes after the table-size boundary: slot 1022 must translate while slot 1023 faults. A design with an off-by-one limit would either map the reserved last slot or reject the last usable one. It lands a flush on a table read that is already in flight. A design without the kill path would cache a stale entry, and the following request would hit with no memory read. It also checks that an invalid entry is never cached, that a single-page drop leaves a neighbour hitting, and that the ninth distinct page evicts the first. A design with broken round-robin order would evict the wrong slot. Finally it changes the base without a flush and confirms the old mapping still hits, which separates a correct unit from one that flushes the cache on its own.

// File: rtl/dmr_pkg.sv
`timescale 1ns/1ps
package dmr_pkg;
  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_BASE = 2'd1,
    RA_SIZE = 2'd2,
    RA_STAT = 2'd3
  } reg_addr_e;

  localparam int CTL_EN_BIT    = 31;
  localparam int CTL_FLUSH_BIT = 30;
  localparam int CTL_INV_BIT   = 29;
  localparam int ENT_VLD_BIT   = 31;

  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_WAIT = 1'b1
  } walk_st_e;
endpackage

// File: rtl/dmr_regs.sv
`timescale 1ns/1ps
module dmr_regs
  import dmr_pkg::*;
#(
  parameter int IDX_W  = 20,
  parameter int BASE_W = 28,
  parameter int SZ_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        waddr,
  input  logic [31:0]       wdata,
  input  logic [1:0]        raddr,
  output logic [31:0]       rdata,
  input  logic              fault_set,
  output logic              en,
  output logic [BASE_W-1:0] base,
  output logic [SZ_W-1:0]   size,
  output logic              flush_pend,
  output logic              inv_pend,
  output logic [IDX_W-1:0]  inv_page,
  output logic              fault_sticky
);
  logic unused_wbits;
  assign unused_wbits = ^wdata;

  logic stat_clr;
  assign stat_clr = wr && (waddr == RA_STAT) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en           <= 1'b0;
      base         <= '0;
      size         <= '0;
      flush_pend   <= 1'b0;
      inv_pend     <= 1'b0;
      inv_page     <= '0;
      fault_sticky <= 1'b0;
    end else begin
      flush_pend <= 1'b0;
      inv_pend   <= 1'b0;
      if (wr) begin
        case (waddr)
          RA_CTRL: begin
            en         <= wdata[CTL_EN_BIT];
            flush_pend <= wdata[CTL_FLUSH_BIT];
            inv_pend   <= wdata[CTL_INV_BIT];
            if (wdata[CTL_INV_BIT]) inv_page <= wdata[IDX_W-1:0];
          end
          RA_BASE: base <= wdata[BASE_W-1:0];
          RA_SIZE: size <= wdata[SZ_W-1:0];
          default: ;
        endcase
      end
      if (fault_set)     fault_sticky <= 1'b1;
      else if (stat_clr) fault_sticky <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (raddr)
      RA_CTRL: begin
        rdata[CTL_EN_BIT]    = en;
        rdata[CTL_FLUSH_BIT] = flush_pend;
        rdata[CTL_INV_BIT]   = inv_pend;
        rdata[IDX_W-1:0]     = inv_page;
      end
      RA_BASE: rdata[BASE_W-1:0] = base;
      RA_SIZE: rdata[SZ_W-1:0]   = size;
      default: rdata[0]          = fault_sticky;
    endcase
  end

  // R8: a flush request lives exactly one cycle unless rewritten
  p_flush_self_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_pend && !wr) |=> !flush_pend);
  // R6: the fault flag holds until software clears it
  p_fault_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_sticky && !stat_clr) |=> fault_sticky);
endmodule

// File: rtl/dmr_tlb.sv
`timescale 1ns/1ps
module dmr_tlb #(
  parameter int N     = 8,
  parameter int TAG_W = 20,
  parameter int DAT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_hit,
  output logic [DAT_W-1:0] look_dat,
  input  logic             fill,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [DAT_W-1:0] fill_dat,
  input  logic             flush_all,
  input  logic             drop_one,
  input  logic [TAG_W-1:0] drop_tag
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  logic             vld [N];
  logic [TAG_W-1:0] tag [N];
  logic [DAT_W-1:0] dat [N];
  logic [N-1:0]     hit_vec;
  logic [PTR_W-1:0] ptr;

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign hit_vec[i] = vld[i] && (tag[i] == look_tag);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[i] <= 1'b0;
        tag[i] <= '0;
        dat[i] <= '0;
      end else if (flush_all) begin
        vld[i] <= 1'b0;
      end else if (drop_one && vld[i] && (tag[i] == drop_tag)) begin
        vld[i] <= 1'b0;
      end else if (fill && (ptr == PTR_W'(i))) begin
        vld[i] <= 1'b1;
        tag[i] <= fill_tag;
        dat[i] <= fill_dat;
      end
    end

    // R8: a flush leaves this slot empty
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> !vld[i]);
    // R9: a matching drop removes this slot
    p_drop_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_one && vld[i] && (tag[i] == drop_tag)) |=> !vld[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (fill && !flush_all) ptr <= (ptr == PTR_W'(N-1)) ? '0 : ptr + 1'b1;
  end

  assign look_hit = |hit_vec;

  always_comb begin
    look_dat = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i]) look_dat = look_dat | dat[i];
  end

  // R5: a page is cached at most once
  p_hit_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/dma_remap.sv
`timescale 1ns/1ps
module dma_remap
  import dmr_pkg::*;
#(
  parameter int PA_W   = 40,
  parameter int BA_W   = 32,
  parameter int PG_SH  = 12,
  parameter int RPN_W  = 24,
  parameter int SZ_W   = 10,
  parameter int TLB_N  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [1:0]      reg_waddr,
  input  logic [31:0]     reg_wdata,
  input  logic [1:0]      reg_raddr,
  output logic [31:0]     reg_rdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PA_W-1:0] req_addr,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            mem_req,
  output logic [PA_W-1:0] mem_addr,
  input  logic            mem_rvalid,
  input  logic [31:0]     mem_rdata
);
  localparam int IDX_W  = BA_W - PG_SH;
  localparam int BASE_W = PA_W - PG_SH;
  localparam int EPP_SH = PG_SH - 2;

  // ---- arithmetic helpers
  function automatic logic [PA_W-1:0] make_phys(input logic [RPN_W-1:0] rpn,
                                                input logic [PG_SH-1:0] off);
    return (PA_W'(rpn) << PG_SH) | PA_W'(off);
  endfunction

  function automatic logic [PA_W-1:0] tbl_addr(input logic [BASE_W-1:0] b,
                                               input logic [IDX_W-1:0] idx);
    return (PA_W'(b) << PG_SH) + (PA_W'(idx) << 2);
  endfunction

  function automatic logic [PA_W-1:0] strip_window(input logic [PA_W-1:0] a);
    return a - (PA_W'(1) << (PA_W-1));
  endfunction

  function automatic logic idx_in_table(input logic [IDX_W-1:0] idx,
                                        input logic [SZ_W-1:0] sz);
    logic [31:0] used, lim;
    used = 32'(idx) + 32'd1;
    lim  = 32'(sz) << EPP_SH;
    return used < lim;
  endfunction

  // ---- register block
  logic              en, flush_pend, inv_pend, fault_sticky, fault_ev;
  logic [BASE_W-1:0] base;
  logic [SZ_W-1:0]   size;
  logic [IDX_W-1:0]  inv_page;

  dmr_regs #(.IDX_W(IDX_W), .BASE_W(BASE_W), .SZ_W(SZ_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .rdata(reg_rdata), .fault_set(fault_ev), .en(en),
    .base(base), .size(size), .flush_pend(flush_pend), .inv_pend(inv_pend),
    .inv_page(inv_page), .fault_sticky(fault_sticky)
  );

  logic unused_stat;
  assign unused_stat = fault_sticky;

  // ---- request decode
  walk_st_e          st;
  logic              kill;
  logic [IDX_W-1:0]  cur_idx;
  logic [PG_SH-1:0]  cur_off;

  logic              maint, is_byp, range_bad;
  logic [IDX_W-1:0]  idx;
  logic [PG_SH-1:0]  off;
  logic              tlb_hit;
  logic [RPN_W-1:0]  tlb_rpn;

  assign maint     = flush_pend || inv_pend;
  assign is_byp    = req_addr[PA_W-1];
  assign idx       = req_addr[BA_W-1:PG_SH];
  assign off       = req_addr[PG_SH-1:0];
  assign range_bad = (|req_addr[PA_W-2:BA_W]) || !idx_in_table(idx, size);
  assign req_ready = (st == WK_IDLE) && !maint;

  // named events
  logic ev_accept, ev_miss, ev_walk_done, ev_fill;
  logic quick_fault;
  logic [PA_W-1:0] quick_paddr;
  logic ent_ok;
  logic [RPN_W-1:0] ent_rpn;
  logic unused_ent;

  assign ent_ok     = mem_rdata[ENT_VLD_BIT];
  assign ent_rpn    = mem_rdata[RPN_W-1:0];
  assign unused_ent = ^mem_rdata;

  assign ev_accept    = req_valid && req_ready;
  assign ev_miss      = ev_accept && !is_byp && en && !range_bad && !tlb_hit;
  assign ev_walk_done = (st == WK_WAIT) && mem_rvalid;
  assign ev_fill      = ev_walk_done && ent_ok && !kill && !maint;
  assign fault_ev     = (ev_accept && !ev_miss && quick_fault) || (ev_walk_done && !ent_ok);

  always_comb begin
    quick_fault = 1'b0;
    quick_paddr = '0;
    if (is_byp)         quick_paddr = strip_window(req_addr);
    else if (!en)       quick_paddr = req_addr;
    else if (range_bad) quick_fault = 1'b1;
    else                quick_paddr = make_phys(tlb_rpn, off);
  end

  dmr_tlb #(.N(TLB_N), .TAG_W(IDX_W), .DAT_W(RPN_W)) u_tlb (
    .clk(clk), .rst_n(rst_n), .look_tag(idx), .look_hit(tlb_hit), .look_dat(tlb_rpn),
    .fill(ev_fill), .fill_tag(cur_idx), .fill_dat(ent_rpn),
    .flush_all(flush_pend), .drop_one(inv_pend), .drop_tag(inv_page)
  );

  // ---- walk sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= WK_IDLE;
      kill      <= 1'b0;
      cur_idx   <= '0;
      cur_off   <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      mem_req   <= 1'b0;
      case (st)
        WK_IDLE: begin
          if (ev_accept) begin
            cur_idx <= idx;
            cur_off <= off;
            kill    <= 1'b0;
            if (ev_miss) begin
              st       <= WK_WAIT;
              mem_req  <= 1'b1;
              mem_addr <= tbl_addr(base, idx);
            end else begin
              rsp_valid <= 1'b1;
              rsp_fault <= quick_fault;
              rsp_paddr <= quick_paddr;
            end
          end
        end
        default: begin
          if (maint) kill <= 1'b1;
          if (mem_rvalid) begin
            st        <= WK_IDLE;
            rsp_valid <= 1'b1;
            rsp_fault <= !ent_ok;
            rsp_paddr <= ent_ok ? make_phys(ent_rpn, cur_off) : '0;
          end
        end
      endcase
    end
  end

  // R4: table reads are single-cycle strobes
  p_mem_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  // R4: a returned table word produces a response next cycle
  p_walk_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_walk_done |=> rsp_valid);
  // R5: a request served without a walk answers next cycle
  p_quick_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !ev_miss) |=> rsp_valid);
  // R6: faults carry a zero address
  p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
  // R10: maintenance during a walk marks the fetch stale
  p_kill_mark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == WK_WAIT) && maint && !mem_rvalid) |=> kill);
  // R13: no acceptance while a walk is outstanding
  p_busy_walk_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WK_WAIT) |-> !req_ready);
endmodule

// File: tb/sim_dma_remap.sv
`timescale 1ns/1ps
module sim_dma_remap;
  localparam int MEM_LAT = 3;
  localparam logic [31:0] C_EN  = 32'h8000_0000;
  localparam logic [31:0] C_FL  = 32'h4000_0000;
  localparam logic [31:0] C_INV = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [39:0] req_addr = '0;
  logic        rsp_valid, rsp_fault;
  logic [39:0] rsp_paddr;
  logic        mem_req;
  logic [39:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  int mem_reads = 0;
  logic [39:0] last_maddr = '0;
  logic [39:0] pend_maddr = '0;
  int mem_cnt = 0;

  always #2 clk = ~clk;

  dma_remap u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  // table contents as a function of the word address
  function automatic logic [23:0] rpn_at(input logic [39:0] ma);
    return ma[25:2] ^ 24'h00A5C3;
  endfunction
  function automatic logic ok_at(input logic [39:0] ma);
    return ma[13:2] != 12'd5;
  endfunction
  function automatic logic [39:0] word_at(input logic [39:0] b, input logic [39:0] a);
    return b * 40'd4096 + 40'(a[31:12]) * 40'd4;
  endfunction
  function automatic logic [39:0] exp_phys(input logic [39:0] b, input logic [39:0] a);
    return {4'b0, rpn_at(word_at(b, a)), a[11:0]};
  endfunction

  // memory model
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (mem_cnt > 0) begin
      mem_cnt--;
      if (mem_cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = {ok_at(pend_maddr), 7'b0, rpn_at(pend_maddr)};
      end
    end
    if (mem_req) begin
      mem_reads++;
      pend_maddr = mem_addr;
      last_maddr = mem_addr;
      mem_cnt    = MEM_LAT;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_raddr = a; #0.5;
    d = reg_rdata;
  endtask

  task automatic do_req(input logic [39:0] a, output logic [39:0] pa, output logic flt,
                        output int lat, output int nrd);
    int r0;
    r0 = mem_reads;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!rsp_valid && lat < 50);
    pa  = rsp_paddr;
    flt = rsp_fault;
    nrd = mem_reads - r0;
  endtask

  // vectors: {address, expect table read, expect fault}
  localparam logic [41:0] VEC [0:8] = '{
    {40'h00_0000_1234, 1'b1, 1'b0},
    {40'h00_0000_1FF0, 1'b0, 1'b0},
    {40'h00_0000_5010, 1'b1, 1'b1},
    {40'h00_0000_5010, 1'b1, 1'b1},
    {40'h80_1234_5678, 1'b0, 1'b0},
    {40'h00_003F_F008, 1'b0, 1'b1},
    {40'h00_003F_EABC, 1'b1, 1'b0},
    {40'h01_0000_0000, 1'b0, 1'b1},
    {40'h00_0000_1000, 1'b0, 1'b0}
  };
  string vtag [0:8] = '{"R4", "R5", "R7", "R7", "R2", "R6", "R6", "R6", "R5"};

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [39:0] pa, ea;
    logic        flt;
    int          lat, nrd;
    logic [31:0] rd;
    logic [39:0] b0, b1;
    b0 = 40'h100;
    b1 = 40'h200;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    // R1 reset state
    chk("R1 ready", 64'(req_ready), 64'd1);
    chk("R1 rsp", 64'(rsp_valid), 64'd0);
    chk("R1 mreq", 64'(mem_req), 64'd0);
    reg_read(2'd0, rd); chk("R1 ctrl", 64'(rd), 64'd0);
    reg_read(2'd3, rd); chk("R1 stat", 64'(rd), 64'd0);

    reg_write(2'd1, 32'(b0));
    reg_write(2'd2, 32'd1);
    reg_write(2'd0, C_EN | C_FL);
    repeat (2) @(negedge clk);

    // table walk over vectors
    for (int k = 0; k < 9; k++) begin
      logic [39:0] a;
      logic em, ef;
      a  = VEC[k][41:2];
      em = VEC[k][1];
      ef = VEC[k][0];
      do_req(a, pa, flt, lat, nrd);
      if (a[39])   ea = a ^ (40'd1 << 39);
      else if (ef) ea = '0;
      else         ea = exp_phys(b0, a);
      chk({vtag[k], " paddr"}, 64'(pa), 64'(ea));
      chk({vtag[k], " fault"}, 64'(flt), 64'(ef));
      chk({vtag[k], " latency"}, 64'(lat), em ? 64'(MEM_LAT + 2) : 64'd1);
      chk({vtag[k], " reads"}, 64'(nrd), em ? 64'd1 : 64'd0);
    end

    // R6 sticky status, write one to clear
    reg_read(2'd3, rd); chk("R6 sticky", 64'(rd[0]), 64'd1);
    reg_write(2'd3, 32'd1);
    reg_read(2'd3, rd); chk("R6 clear", 64'(rd[0]), 64'd0);

    // R4 table word address
    do_req(40'h33_000, pa, flt, lat, nrd);
    chk("R4 maddr", 64'(last_maddr), 64'(b0 * 4096 + 40'h33 * 4));
    chk("R4 paddr", 64'(pa), 64'(exp_phys(b0, 40'h33_000)));

    // R3 disabled passes through
    reg_write(2'd0, 32'd0);
    do_req(40'h00_0000_7777, pa, flt, lat, nrd);
    chk("R3 paddr", 64'(pa), 64'h7777);
    chk("R3 reads", 64'(nrd), 64'd0);
    chk("R3 latency", 64'(lat), 64'd1);
    reg_write(2'd0, C_EN);

    // R8 flush, R13 stall
    reg_write(2'd0, C_EN | C_FL);
    reg_read(2'd0, rd); chk("R8 bit set", 64'(rd[30]), 64'd1);
    chk("R13 ready low", 64'(req_ready), 64'd0);
    @(posedge clk); #1;
    reg_read(2'd0, rd); chk("R8 bit clear", 64'(rd[30]), 64'd0);
    do_req(40'h00_0000_1000, pa, flt, lat, nrd);
    chk("R8 refetch", 64'(nrd), 64'd1);

    // R9 single page drop
    do_req(40'h14_000, pa, flt, lat, nrd);
    do_req(40'h15_000, pa, flt, lat, nrd);
    reg_write(2'd0, C_EN | C_INV | 32'h14);
    @(posedge clk); #1;
    reg_read(2'd0, rd); chk("R9 bit clear", 64'(rd[29]), 64'd0);
    do_req(40'h15_000, pa, flt, lat, nrd);
    chk("R9 other hits", 64'(nrd), 64'd0);
    do_req(40'h14_000, pa, flt, lat, nrd);
    chk("R9 dropped", 64'(nrd), 64'd1);

    // R10 flush during an outstanding walk
    fork
      do_req(40'h16_000, pa, flt, lat, nrd);
      begin repeat (2) @(negedge clk); reg_write(2'd0, C_EN | C_FL); end
    join
    chk("R10 paddr", 64'(pa), 64'(exp_phys(b0, 40'h16_000)));
    chk("R10 fault", 64'(flt), 64'd0);
    do_req(40'h16_000, pa, flt, lat, nrd);
    chk("R10 not cached", 64'(nrd), 64'd1);

    // R11 base change without flush
    reg_write(2'd1, 32'(b1));
    do_req(40'h16_000, pa, flt, lat, nrd);
    chk("R11 still hits", 64'(nrd), 64'd0);
    chk("R11 old map", 64'(pa), 64'(exp_phys(b0, 40'h16_000)));
    reg_write(2'd0, C_EN | C_FL);
    do_req(40'h16_000, pa, flt, lat, nrd);
    chk("R11 new base", 64'(last_maddr), 64'(b1 * 4096 + 40'h16 * 4));
    chk("R11 new map", 64'(pa), 64'(exp_phys(b1, 40'h16_000)));

    // R12 round-robin replacement
    reg_write(2'd0, C_EN | C_FL);
    for (int p = 0; p < 9; p++) begin
      do_req(40'(32'h30 + p) << 12, pa, flt, lat, nrd);
      chk("R12 fill", 64'(nrd), 64'd1);
    end
    do_req(40'h31_000, pa, flt, lat, nrd);
    chk("R12 second kept", 64'(nrd), 64'd0);
    do_req(40'h30_000, pa, flt, lat, nrd);
    chk("R12 first evicted", 64'(nrd), 64'd1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule